// File: doc/BRIEF.md
# Compact Instruction Expander (byte/halfword memory, in-place unary and multiply group)

This block takes one 16-bit compressed instruction and rewrites it into the equivalent 32-bit base-ISA instruction. It covers one small group of the compressed space. That group holds byte and halfword loads and stores with a two-bit offset, in-place zero and sign extension, bitwise inversion, and a two-register multiply. Any pattern outside that group is reported as no hit, and the rest of the decoder handles it.

Configuration inputs say which extensions are enabled: the group itself, basic bit manipulation, address-generation bit manipulation, full multiply/divide, multiply-only, and 64-bit XLEN. When a pattern belongs to the group but an extension it needs is off, or its code is reserved, the block raises `illegal` and outputs a zero word. An optional register stage, selected by a parameter, sits at the output. It is on by default, so results appear one clock after the input is applied.

Top module: `cx_expand`

## Requirements
- R1: With the group enabled, a pattern with bits 15:13=100, 12:10=000 and 1:0=00 expands to an unsigned byte load: I-type, opcode 0000011, funct3 100. Here rs1 is x(8+bits 9:7), rd is x(8+bits 4:2), and the immediate is zero-extended {bit5, bit6}.
- R2: The pattern with 12:10=001 in the same quadrant is a halfword load. Bit 6=0 gives the unsigned form (funct3 101) and bit 6=1 gives the signed form (funct3 001). The immediate is {bit5, 0}.
- R3: 12:10=010 expands to a byte store and 12:10=011 to a halfword store. Both are S-type with opcode 0100011 and funct3 000 or 001, rs1 from bits 9:7 and rs2 from bits 4:2. The offset is {bit5, bit6} for the byte store and {bit5, 0} for the halfword store. A halfword store with bit 6=1 is not a hit.
- R4: Quadrant 01 patterns with bits 15:13=100, 12:10=111 and 6:5=11 select a unary operation through bits 4:2, acting on x(8+bits 9:7). Code 000 expands to andi rd,rd,0xFF and code 101 expands to xori rd,rd,-1. Both need only the group enable.
- R5: Code 001 (sign-extend byte, imm 0x604) and code 011 (sign-extend halfword, imm 0x605) expand to opcode 0010011 with funct3 001, and both need bit-manipulation. Code 010 (zero-extend halfword) also needs bit-manipulation. It expands to funct7 0000100, rs2 x0, funct3 100, with opcode 0110011 when XLEN is 32 and 0111011 when XLEN is 64.
- R6: Code 100 expands to add.uw rd,rd,x0 (funct7 0000100, funct3 000, opcode 0111011). It needs both address-generation bit-manipulation and 64-bit XLEN, and is illegal otherwise.
- R7: 6:5=10 expands to mul rd,rd,rs2, with rs2 from bits 4:2, funct7 0000001, funct3 000 and opcode 0110011. It needs full multiply or multiply-only support.
- R8: Unary codes 110 and 111 are reserved. With the group enabled they give hit=1, illegal=1.
- R9: With the group enable low, no pattern gives hit or illegal, and the output word is zero.
- R10: The output word is zero whenever hit is low or illegal is high. Patterns outside the group give no hit. This includes quadrant 01 with 6:5 of 00 or 01, quadrant 00 minor codes 1xx, other quadrants, and other bits 15:13.
- R11: With the register stage on, outputs reflect the inputs sampled at the previous rising clock edge. An active-low reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cinsn | input | 16 | Compressed instruction |
| en_cb | input | 1 | Group enable |
| en_bitmanip | input | 1 | Basic bit-manipulation present |
| en_addrgen | input | 1 | Address-generation bit-manipulation present |
| en_mul | input | 1 | Full multiply/divide present |
| en_mulonly | input | 1 | Multiply-only subset present |
| xlen64 | input | 1 | XLEN is 64 |
| xinsn | output | 32 | Expanded instruction, zero when not a legal hit |
| hit | output | 1 | Pattern belongs to the group and the group is enabled |
| illegal | output | 1 | Group pattern that is reserved or lacks a prerequisite |

## Verification
The bench sweeps every register pair, offset and operation under all 64 combinations of the six configuration inputs. It compares each output against words built by an encoder of its own. The corner cases it targets are these:
- offset bit swapping (bit 6 is the low offset bit), which a design that read it the other way would turn into the wrong immediate;
- the signed and unsigned halfword load split on bit 6;
- a halfword store with bit 6 set, which a loose decoder would accept;
- zext.h, whose opcode changes with XLEN, and add.uw, which a design might let through on a 32-bit configuration;
- the reserved unary codes, which an incomplete decoder would report as no hit instead of illegal.

// File: rtl/cx_pkg.sv
package cx_pkg;
   typedef enum logic [3:0] {
      CX_NONE, CX_LBU, CX_LHU, CX_LH, CX_SB, CX_SH,
      CX_ZEXTB, CX_SEXTB, CX_ZEXTH, CX_SEXTH, CX_ZEXTW,
      CX_NOT, CX_MUL, CX_RSVD
   } cx_op_e;

   localparam logic [2:0] CX_PREFIX = 3'b100;
   localparam logic [2:0] CX_ALUGRP = 3'b111;
   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;
   localparam logic [6:0] OPC_OPIMM = 7'b0010011;
   localparam logic [6:0] OPC_OP    = 7'b0110011;
   localparam logic [6:0] OPC_OP32  = 7'b0111011;
endpackage

// File: rtl/cx_classify.sv
module cx_classify
   import cx_pkg::*;
(
   input  logic [5:0] c_hi,   // bits 15:10
   input  logic [6:0] c_lo,   // bits 6:0
   input  logic       en_cb,
   output cx_op_e     op
);
   logic [2:0] prefix, minor, sel;
   logic [1:0] quad, kind;
   logic       b6;

   assign prefix = c_hi[5:3];
   assign minor  = c_hi[2:0];
   assign b6     = c_lo[6];
   assign kind   = c_lo[6:5];
   assign sel    = c_lo[4:2];
   assign quad   = c_lo[1:0];

   always_comb begin
      op = CX_NONE;
      if (en_cb && prefix == CX_PREFIX) begin
         if (quad == 2'b00) begin
            case (minor)
               3'b000:  op = CX_LBU;
               3'b001:  op = b6 ? CX_LH : CX_LHU;
               3'b010:  op = CX_SB;
               3'b011:  op = b6 ? CX_NONE : CX_SH;
               default: op = CX_NONE;
            endcase
         end else if (quad == 2'b01 && minor == CX_ALUGRP) begin
            if (kind == 2'b10) begin
               op = CX_MUL;
            end else if (kind == 2'b11) begin
               case (sel)
                  3'b000:  op = CX_ZEXTB;
                  3'b001:  op = CX_SEXTB;
                  3'b010:  op = CX_ZEXTH;
                  3'b011:  op = CX_SEXTH;
                  3'b100:  op = CX_ZEXTW;
                  3'b101:  op = CX_NOT;
                  default: op = CX_RSVD;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/cx_prereq.sv
module cx_prereq
   import cx_pkg::*;
(
   input  cx_op_e op,
   input  logic   en_bitmanip,
   input  logic   en_addrgen,
   input  logic   en_mul,
   input  logic   en_mulonly,
   input  logic   xlen64,
   output logic   hit,
   output logic   illegal
);
   logic granted;

   always_comb begin
      case (op)
         CX_SEXTB, CX_ZEXTH, CX_SEXTH: granted = en_bitmanip;
         CX_ZEXTW:                     granted = en_addrgen & xlen64;
         CX_MUL:                       granted = en_mul | en_mulonly;
         CX_RSVD, CX_NONE:             granted = 1'b0;
         default:                      granted = 1'b1;
      endcase
   end

   assign hit     = (op != CX_NONE);
   assign illegal = hit & ~granted;
endmodule

// File: rtl/cx_encode.sv
module cx_encode
   import cx_pkg::*;
#(
   parameter int RW       = 5,
   parameter int CREG_OFS = 8,
   parameter int W_W      = 32
) (
   input  cx_op_e           op,
   input  logic [7:0]       c_mid,  // bits 9:2
   input  logic             xlen64,
   output logic [W_W-1:0]   word
);
   localparam int IMM_W = 12;

   function automatic logic [RW-1:0] creg(input logic [2:0] f);
      return RW'(CREG_OFS) + RW'(f);
   endfunction

   logic [RW-1:0]    ra, rb;
   logic [IMM_W-1:0] imm_b, imm_h;

   assign ra    = creg(c_mid[7:5]);
   assign rb    = creg(c_mid[2:0]);
   assign imm_b = {{(IMM_W-2){1'b0}}, c_mid[3], c_mid[4]};
   assign imm_h = {{(IMM_W-2){1'b0}}, c_mid[3], 1'b0};

   always_comb begin
      word = '0;
      case (op)
         CX_LBU:   word = {imm_b, ra, 3'b100, rb, OPC_LOAD};
         CX_LHU:   word = {imm_h, ra, 3'b101, rb, OPC_LOAD};
         CX_LH:    word = {imm_h, ra, 3'b001, rb, OPC_LOAD};
         CX_SB:    word = {imm_b[11:5], rb, ra, 3'b000, imm_b[4:0], OPC_STORE};
         CX_SH:    word = {imm_h[11:5], rb, ra, 3'b001, imm_h[4:0], OPC_STORE};
         CX_ZEXTB: word = {12'h0FF, ra, 3'b111, ra, OPC_OPIMM};
         CX_NOT:   word = {12'hFFF, ra, 3'b100, ra, OPC_OPIMM};
         CX_SEXTB: word = {12'h604, ra, 3'b001, ra, OPC_OPIMM};
         CX_SEXTH: word = {12'h605, ra, 3'b001, ra, OPC_OPIMM};
         CX_ZEXTH: word = {7'b0000100, 5'd0, ra, 3'b100, ra,
                           (xlen64 ? OPC_OP32 : OPC_OP)};
         CX_ZEXTW: word = {7'b0000100, 5'd0, ra, 3'b000, ra, OPC_OP32};
         CX_MUL:   word = {7'b0000001, rb, ra, 3'b000, ra, OPC_OP};
         default:  word = '0;
      endcase
   end
endmodule

// File: rtl/cx_expand.sv
module cx_expand
   import cx_pkg::*;
#(
   parameter int C_W       = 16,
   parameter int W_W       = 32,
   parameter int RW        = 5,
   parameter int CREG_OFS  = 8,
   parameter bit REG_STAGE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [C_W-1:0] cinsn,
   input  logic           en_cb,
   input  logic           en_bitmanip,
   input  logic           en_addrgen,
   input  logic           en_mul,
   input  logic           en_mulonly,
   input  logic           xlen64,
   output logic [W_W-1:0] xinsn,
   output logic           hit,
   output logic           illegal
);
   localparam int NREG = 1 << RW;

   if (C_W != 16) begin : g_cw_bad
      $error("cx_expand: C_W must be 16");
   end
   if (W_W != 32) begin : g_ww_bad
      $error("cx_expand: W_W must be 32");
   end
   if (CREG_OFS + 8 > NREG) begin : g_ofs_bad
      $error("cx_expand: compressed register window exceeds register file");
   end

   cx_op_e         op;
   logic [W_W-1:0] word_raw, word_nx;
   logic           hit_nx, ill_nx;

   cx_classify u_cls (
      .c_hi  (cinsn[15:10]),
      .c_lo  (cinsn[6:0]),
      .en_cb (en_cb),
      .op    (op)
   );

   cx_prereq u_pre (
      .op          (op),
      .en_bitmanip (en_bitmanip),
      .en_addrgen  (en_addrgen),
      .en_mul      (en_mul),
      .en_mulonly  (en_mulonly),
      .xlen64      (xlen64),
      .hit         (hit_nx),
      .illegal     (ill_nx)
   );

   cx_encode #(.RW(RW), .CREG_OFS(CREG_OFS), .W_W(W_W)) u_enc (
      .op     (op),
      .c_mid  (cinsn[9:2]),
      .xlen64 (xlen64),
      .word   (word_raw)
   );

   assign word_nx = (hit_nx && !ill_nx) ? word_raw : '0;

   if (REG_STAGE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            xinsn   <= '0;
            hit     <= 1'b0;
            illegal <= 1'b0;
         end else begin
            xinsn   <= word_nx;
            hit     <= hit_nx;
            illegal <= ill_nx;
         end
      end
   end else begin : g_comb
      assign xinsn   = word_nx;
      assign hit     = hit_nx;
      assign illegal = ill_nx;
   end
endmodule

// File: rtl/cx_expand_chk.sv
module cx_expand_chk #(
   parameter bit REG_STAGE = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cinsn,
   input logic        en_cb,
   input logic        en_mul,
   input logic        en_mulonly,
   input logic [31:0] xinsn,
   input logic        hit,
   input logic        illegal
);
   logic is_rsvd, is_mul, is_lbu;
   assign is_rsvd = en_cb && cinsn[15:10] == 6'b100111 && cinsn[6:5] == 2'b11
                    && cinsn[4:3] == 2'b11 && cinsn[1:0] == 2'b01;
   assign is_mul  = en_cb && cinsn[15:10] == 6'b100111 && cinsn[6:5] == 2'b10
                    && cinsn[1:0] == 2'b01;
   assign is_lbu  = en_cb && cinsn[15:10] == 6'b100000 && cinsn[1:0] == 2'b00;

   // R10
   illegal_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> hit);
   // R10
   quiet_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit || illegal) |-> xinsn == 32'd0);

   if (REG_STAGE) begin : g_seq
      // R9
      off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(en_cb)) |-> (!hit && !illegal));
      // R8
      rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(is_rsvd)) |-> (hit && illegal));
      // R7
      mul_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(is_mul) && !$past(en_mul) && !$past(en_mulonly))
         |-> illegal);
      // R7
      mul_rs2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(is_mul) && !illegal)
         |-> xinsn[24:20] == {2'b01, $past(cinsn[4:2])});
      // R1
      lbu_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(is_lbu))
         |-> xinsn[19:15] == {2'b01, $past(cinsn[9:7])});
   end else begin : g_cmb
      // R9
      off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en_cb |-> (!hit && !illegal));
      // R8
      rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         is_rsvd |-> (hit && illegal));
      // R7
      mul_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_mul && !en_mul && !en_mulonly) |-> illegal);
      // R7
      mul_rs2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_mul && !illegal) |-> xinsn[24:20] == {2'b01, cinsn[4:2]});
      // R1
      lbu_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
         is_lbu |-> xinsn[19:15] == {2'b01, cinsn[9:7]});
   end
endmodule

bind cx_expand cx_expand_chk #(.REG_STAGE(REG_STAGE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cinsn      (cinsn),
   .en_cb      (en_cb),
   .en_mul     (en_mul),
   .en_mulonly (en_mulonly),
   .xinsn      (xinsn),
   .hit        (hit),
   .illegal    (illegal)
);

// File: tb/tb_cx_expand.sv
`timescale 1ns/1ps
module tb_cx_expand;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cinsn = '0;
   logic        en_cb = 1'b0, en_bitmanip = 1'b0, en_addrgen = 1'b0;
   logic        en_mul = 1'b0, en_mulonly = 1'b0, xlen64 = 1'b0;
   logic [31:0] xinsn;
   logic        hit, illegal;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cx_expand dut (
      .clk(clk), .rst_n(rst_n), .cinsn(cinsn), .en_cb(en_cb),
      .en_bitmanip(en_bitmanip), .en_addrgen(en_addrgen), .en_mul(en_mul),
      .en_mulonly(en_mulonly), .xlen64(xlen64),
      .xinsn(xinsn), .hit(hit), .illegal(illegal)
   );

   // mnemonic indices of the reference encoder
   localparam int M_LBU = 0, M_LHU = 1, M_LH = 2, M_SB = 3, M_SH = 4,
                  M_ZXB = 5, M_SXB = 6, M_ZXH = 7, M_SXH = 8, M_ZXW = 9,
                  M_NOT = 10, M_MUL = 11;

   function automatic logic [15:0] enc16(int m, int a, int b, int off);
      logic [2:0] fa = 3'(a), fb = 3'(b);
      logic o0 = off[0], o1 = off[1];
      case (m)
         M_LBU: return {3'b100, 3'b000, fa, o0, o1, fb, 2'b00};
         M_LHU: return {3'b100, 3'b001, fa, 1'b0, o1, fb, 2'b00};
         M_LH:  return {3'b100, 3'b001, fa, 1'b1, o1, fb, 2'b00};
         M_SB:  return {3'b100, 3'b010, fa, o0, o1, fb, 2'b00};
         M_SH:  return {3'b100, 3'b011, fa, 1'b0, o1, fb, 2'b00};
         M_MUL: return {3'b100, 3'b111, fa, 2'b10, fb, 2'b01};
         M_ZXB: return {3'b100, 3'b111, fa, 2'b11, 3'd0, 2'b01};
         M_SXB: return {3'b100, 3'b111, fa, 2'b11, 3'd1, 2'b01};
         M_ZXH: return {3'b100, 3'b111, fa, 2'b11, 3'd2, 2'b01};
         M_SXH: return {3'b100, 3'b111, fa, 2'b11, 3'd3, 2'b01};
         M_ZXW: return {3'b100, 3'b111, fa, 2'b11, 3'd4, 2'b01};
         default: return {3'b100, 3'b111, fa, 2'b11, 3'd5, 2'b01};
      endcase
   endfunction

   function automatic logic [31:0] enc32(int m, int a, int b, int off, bit x64);
      logic [4:0]  ra = 5'(a + 8), rb = 5'(b + 8);
      logic [11:0] im = 12'(off);
      case (m)
         M_LBU, M_LHU, M_LH: begin
            logic [2:0] f3 = (m == M_LBU) ? 3'b100 : (m == M_LHU) ? 3'b101 : 3'b001;
            return {im, ra, f3, rb, 7'b0000011};
         end
         M_SB:  return {7'd0, rb, ra, 3'b000, im[4:0], 7'b0100011};
         M_SH:  return {7'd0, rb, ra, 3'b001, im[4:0], 7'b0100011};
         M_ZXB: return {12'd255, ra, 3'b111, ra, 7'b0010011};
         M_NOT: return {12'hFFF, ra, 3'b100, ra, 7'b0010011};
         M_SXB: return {12'h604, ra, 3'b001, ra, 7'b0010011};
         M_SXH: return {12'h605, ra, 3'b001, ra, 7'b0010011};
         M_ZXH: return {7'b0000100, 5'd0, ra, 3'b100, ra, x64 ? 7'b0111011 : 7'b0110011};
         M_ZXW: return {7'b0000100, 5'd0, ra, 3'b000, ra, 7'b0111011};
         default: return {7'b0000001, rb, ra, 3'b000, ra, 7'b0110011};
      endcase
   endfunction

   // flags f = {xlen64, en_mulonly, en_mul, en_addrgen, en_bitmanip, en_cb}
   function automatic bit granted(int m, logic [5:0] f);
      case (m)
         M_SXB, M_ZXH, M_SXH: return f[1];
         M_ZXW:               return f[2] & f[5];
         M_MUL:               return f[3] | f[4];
         default:             return 1'b1;
      endcase
   endfunction

   function automatic string tag_of(int m);
      case (m)
         M_LBU: return "R1";
         M_LHU, M_LH: return "R2";
         M_SB, M_SH: return "R3";
         M_ZXB, M_NOT: return "R4";
         M_SXB, M_ZXH, M_SXH: return "R5";
         M_ZXW: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic compare(string tag, logic [31:0] ew, logic eh, logic ei);
      n_vec++;
      if (xinsn !== ew || hit !== eh || illegal !== ei) begin
         n_bad++;
         $display("FAIL %s c=%h flags=%b actual w=%h hit=%b ill=%b expected w=%h hit=%b ill=%b",
                  tag, cinsn, {xlen64, en_mulonly, en_mul, en_addrgen, en_bitmanip, en_cb},
                  xinsn, hit, illegal, ew, eh, ei);
      end
   endtask

   task automatic apply(logic [15:0] c, logic [5:0] f, string tag,
                        logic [31:0] ew, logic eh, logic ei);
      @(negedge clk);
      cinsn = c;
      {xlen64, en_mulonly, en_mul, en_addrgen, en_bitmanip, en_cb} = f;
      @(posedge clk);
      #1;
      compare(tag, ew, eh, ei);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] junk [6];
      junk[0] = 16'b100_0_11_001_00_010_01;  // quadrant 01, 6:5=00
      junk[1] = 16'b100_1_11_001_01_010_01;  // quadrant 01, 6:5=01
      junk[2] = 16'b100_100_001_0_0_010_00;  // quadrant 00 minor 100
      junk[3] = 16'b100_011_001_1_0_010_00;  // halfword store, bit6=1
      junk[4] = 16'b100_000_001_0_0_010_10;  // quadrant 10
      junk[5] = 16'b010_000_001_0_0_010_00;  // other prefix

      // R11: reset holds outputs at zero even with a valid pattern applied
      cinsn = enc16(M_LBU, 1, 2, 3);
      en_cb = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      compare("R11", 32'd0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: one register stage of latency
      apply(enc16(M_LBU, 1, 2, 3), 6'b000001, "R1", enc32(M_LBU, 1, 2, 3, 1'b0), 1'b1, 1'b0);
      @(negedge clk);
      cinsn = enc16(M_NOT, 4, 0, 0);
      #1;
      compare("R11", enc32(M_LBU, 1, 2, 3, 1'b0), 1'b1, 1'b0);
      @(posedge clk);
      #1;
      compare("R11", enc32(M_NOT, 4, 0, 0, 1'b0), 1'b1, 1'b0);

      for (int fi = 0; fi < 64; fi++) begin
         logic [5:0] f = 6'(fi);
         for (int m = 0; m <= M_MUL; m++) begin
            for (int a = 0; a < 8; a++) begin
               for (int b = 0; b < 8; b++) begin
                  for (int off = 0; off < 4; off++) begin
                     bit two_reg = (m <= M_SH) || (m == M_MUL);
                     bit byte_off = (m == M_LBU) || (m == M_SB);
                     bit half_off = (m == M_LHU) || (m == M_LH) || (m == M_SH);
                     bit eh, ei;
                     if (!two_reg && b != 0) continue;
                     if (!byte_off && !half_off && off != 0) continue;
                     if (half_off && off[0]) continue;
                     eh = f[0];
                     ei = f[0] && !granted(m, f);
                     apply(enc16(m, a, b, off), f, f[0] ? tag_of(m) : "R9",
                           (eh && !ei) ? enc32(m, a, b, off, f[5]) : 32'd0, eh, ei);
                  end
               end
            end
         end
         // R8: reserved unary codes
         for (int a = 0; a < 8; a++) begin
            for (int k = 6; k < 8; k++) begin
               apply({3'b100, 3'b111, 3'(a), 2'b11, 3'(k), 2'b01}, f,
                     f[0] ? "R8" : "R9", 32'd0, f[0], f[0]);
            end
         end
         // R10: patterns outside the group
         for (int j = 0; j < 6; j++) begin
            apply(junk[j], f, "R10", 32'd0, 1'b0, 1'b0);
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule